// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits between the infrared physical layer and the receive FIFO. It counts the bytes of each incoming frame and passes bytes on to the FIFO only while the frame stays within a programmed maximum length. The byte that would go past the limit is dropped and raises a sticky exceeded flag. Every later byte of that frame is dropped as well, until the physical layer reports the next frame start.

The maximum length is 13 bits wide and is written as two byte-wide halves. A live count of the bytes received in the current frame is always visible on an output port. Bytes that arrive between an end-of-frame indication and the next start flag do not belong to any frame. They are neither counted nor written.

Top module: `rx_frame_limiter`

## Requirements
- R1: After reset the byte count reads 0, the exceeded flag is 0, the limit is 0, and no FIFO write occurs.
- R2: A write with `lim_lo_we` loads `lim_wdata[7:0]` into limit bits 7:0. A write with `lim_hi_we` loads `lim_wdata[4:0]` into limit bits 12:8, and `lim_wdata[7:5]` is ignored.
- R3: Each in-frame byte (`byte_vld` high) adds one to `rx_count`, with the new value visible after the clock edge that takes the byte.
- R4: An in-frame byte that arrives while the count before it is below the limit raises `fifo_we` in the same cycle, with `fifo_wdata` equal to `byte_data`. At most `limit` bytes of a frame are written.
- R5: An in-frame byte that arrives when the count before it is at or above the limit is not written, and `exceed_flag` reads 1 from the next cycle on.
- R6: Once a frame has dropped a byte, no further byte of that frame is written, even if the limit is raised afterwards.
- R7: `frm_start` clears the count and re-enables writes. A byte given in the same cycle as `frm_start` is the first byte of the new frame.
- R8: `exceed_flag` survives frame starts. It is cleared by `exceed_clr` or `status_rd`, and a new exceed event in the same cycle keeps it set.
- R9: `rx_count` saturates at 8191 and does not wrap.
- R10: Bytes outside a frame are ignored: no write and no count change. "Outside a frame" means after reset or after `frm_end`, and before the next `frm_start`. A byte given together with `frm_end` still belongs to the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lim_lo_we | input | 1 | Load limit bits 7:0 |
| lim_hi_we | input | 1 | Load limit bits 12:8 |
| lim_wdata | input | 8 | Limit write data |
| frm_start | input | 1 | Frame start flag pulse |
| frm_end | input | 1 | End-of-frame pulse |
| byte_vld | input | 1 | Received byte valid |
| byte_data | input | 8 | Received byte |
| exceed_clr | input | 1 | Clear the exceeded flag |
| status_rd | input | 1 | Status read, clears the exceeded flag |
| fifo_we | output | 1 | Write enable toward the receive FIFO |
| fifo_wdata | output | 8 | Data toward the receive FIFO |
| exceed_flag | output | 1 | Maximum length exceeded (sticky) |
| rx_count | output | 13 | Bytes received in the current frame |

## Verification
A table drives a limit-3 frame through its accepted bytes, its overrun bytes, a restart with a byte in the start cycle, a byte on the end flag, and a stray byte after the end. This separates "counting" from "writing" and "in frame" from "outside a frame". Directed cases cover the following:
- masking of the high limit byte;
- a limit of zero;
- a limit raised after an overrun, which tells a latched block apart from a plain compare;
- flag clearing against a simultaneous set;
- a full-range 8192-byte frame, which shows the last legal byte written and the count held at 8191.

// File: rtl/rx_frame_limiter.sv
module rx_frame_limiter #(
  parameter int CNT_W  = 13,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_lo_we,
  input  logic              lim_hi_we,
  input  logic [BYTE_W-1:0] lim_wdata,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              exceed_clr,
  input  logic              status_rd,
  output logic              fifo_we,
  output logic [BYTE_W-1:0] fifo_wdata,
  output logic              exceed_flag,
  output logic [CNT_W-1:0]  rx_count
);
  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] limit, cnt, base;
  logic blk, in_frame, take, over;

  assign base    = frm_start ? '0 : cnt;
  assign take    = byte_vld & (frm_start | in_frame);
  assign over    = take & ((blk & ~frm_start) | (base >= limit));
  assign fifo_we = take & ~over;
  assign fifo_wdata = byte_data;
  assign rx_count   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit       <= '0;
      cnt         <= '0;
      blk         <= 1'b0;
      in_frame    <= 1'b0;
      exceed_flag <= 1'b0;
    end else begin
      if (lim_lo_we) limit[BYTE_W-1:0]     <= lim_wdata;
      if (lim_hi_we) limit[CNT_W-1:BYTE_W] <= lim_wdata[HI_W-1:0];
      if (take)           cnt <= (base == CNT_MAX) ? base : base + CNT_W'(1);
      else if (frm_start) cnt <= '0;
      blk         <= over ? 1'b1 : (frm_start ? 1'b0 : blk);
      in_frame    <= frm_end ? 1'b0 : (frm_start ? 1'b1 : in_frame);
      exceed_flag <= over ? 1'b1 : ((exceed_clr | status_rd) ? 1'b0 : exceed_flag);
    end
  end

  p_blocked_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk && !frm_start |-> !fifo_we);
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && !byte_vld |=> rx_count == '0);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exceed_flag && !exceed_clr && !status_rd |=> exceed_flag);
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == CNT_MAX && !frm_start |=> rx_count == CNT_MAX);
  p_outside_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame && !frm_start |-> !fifo_we);
  p_drop_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && (frm_start || in_frame) && !fifo_we |=> exceed_flag);
endmodule

// File: tb/rx_frame_limiter_tb.sv
module rx_frame_limiter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lim_lo_we = 0, lim_hi_we = 0, frm_start = 0, frm_end = 0, byte_vld = 0;
  logic exceed_clr = 0, status_rd = 0;
  logic [7:0] lim_wdata = 0, byte_data = 0, fifo_wdata;
  logic fifo_we, exceed_flag;
  logic [12:0] rx_count;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rx_frame_limiter u_dut (.*);

  // {start, end, vld, exp_we, exp_flag, exp_cnt[12:0]}, limit = 3
  localparam int N = 11;
  localparam logic [17:0] VEC [N] = '{
    {5'b10000, 13'd0}, {5'b00110, 13'd1}, {5'b00110, 13'd2}, {5'b00110, 13'd3},
    {5'b00101, 13'd4}, {5'b00101, 13'd5}, {5'b10111, 13'd1}, {5'b01111, 13'd2},
    {5'b00101, 13'd2}, {5'b10001, 13'd0}, {5'b00111, 13'd1}};

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic en, input logic v, input logic [7:0] d);
    frm_start = st; frm_end = en; byte_vld = v; byte_data = d;
    #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
    frm_start = 0; frm_end = 0; byte_vld = 0; exceed_clr = 0; status_rd = 0;
    lim_lo_we = 0; lim_hi_we = 0;
  endtask

  task automatic set_lim(input logic [7:0] lo, input logic [7:0] hi);
    lim_lo_we = 1; lim_hi_we = 1; lim_wdata = lo; #1; tick;
    lim_lo_we = 0; lim_hi_we = 1; lim_wdata = hi; #1; tick;
  endtask

  task automatic clr_flag;
    status_rd = 1; #1; tick;
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9; rst_n = 1; @(posedge clk); #1;
    chk("R1 count", rx_count, 0);
    chk("R1 flag", 13'(exceed_flag), 0);
    cyc(1, 0, 1, 8'h11);
    chk("R1 limit zero blocks", 13'(fifo_we), 0);
    tick;
    clr_flag;
    chk("R8 status read clears", 13'(exceed_flag), 0);

    set_lim(8'd3, 8'd0);
    for (int i = 0; i < N; i++) begin
      cyc(VEC[i][17], VEC[i][16], VEC[i][15], 8'(i * 7 + 1));
      chk($sformatf("R4/R5/R10 we vec %0d", i), 13'(fifo_we), 13'(VEC[i][14]));
      if (fifo_we) chk("R4 data", 13'(fifo_wdata), 13'(i * 7 + 1));
      tick;
      chk($sformatf("R3/R7/R10 cnt vec %0d", i), rx_count, VEC[i][12:0]);
      chk($sformatf("R5/R8 flag vec %0d", i), 13'(exceed_flag), 13'(VEC[i][13]));
    end

    // R2: high bits 7:5 ignored; limit = 2
    clr_flag;
    set_lim(8'd2, 8'hE0);
    cyc(1, 0, 1, 1); chk("R2 byte1", 13'(fifo_we), 1); tick;
    cyc(0, 0, 1, 2); chk("R2 byte2", 13'(fifo_we), 1); tick;
    cyc(0, 0, 1, 3); chk("R2 byte3 dropped", 13'(fifo_we), 0); tick;
    chk("R5 flag", 13'(exceed_flag), 1);
    // R6: raising the limit does not reopen the frame
    set_lim(8'd100, 8'd0);
    cyc(0, 0, 1, 4); chk("R6 still blocked", 13'(fifo_we), 0); tick;
    chk("R3 counts dropped bytes", rx_count, 4);
    cyc(1, 0, 0, 0); tick;
    cyc(0, 0, 1, 5); chk("R7 reopened", 13'(fifo_we), 1); tick;
    chk("R8 sticky over start", 13'(exceed_flag), 1);

    // R8: set wins over clear
    set_lim(8'd0, 8'd0);
    exceed_clr = 1; cyc(1, 0, 1, 6); tick;
    chk("R8 set wins", 13'(exceed_flag), 1);
    exceed_clr = 1; #1; tick;
    chk("R8 clr", 13'(exceed_flag), 0);

    // R9: full range
    set_lim(8'hFF, 8'h1F);
    cyc(1, 0, 0, 0); tick;
    for (int i = 1; i <= 8190; i++) begin cyc(0, 0, 1, 8'(i)); tick; end
    cyc(0, 0, 1, 8'h5A); chk("R4 byte 8191 written", 13'(fifo_we), 1); tick;
    chk("R9 count 8191", rx_count, 13'd8191);
    chk("R9 no flag yet", 13'(exceed_flag), 0);
    cyc(0, 0, 1, 8'h5B); chk("R5 byte 8192 dropped", 13'(fifo_we), 0); tick;
    chk("R9 saturated", rx_count, 13'd8191);
    chk("R5 flag set", 13'(exceed_flag), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule